// File: doc/BRIEF.md
# Serial ADC Host Reader with Power Control

This block is the host-side master for a 12-bit serial analog-to-digital converter that returns 16-bit frames. It owns the converter's chip-select and serial clock lines. It derives the serial clock from the system clock and shifts in the converter's data line. A single-bit command selects one of two operations. A read runs one full frame and returns the 12-bit sample with a one-cycle valid strobe. A power-down command starts a frame and releases chip-select early, which tells the converter to shut down its analog section.

The block tracks whether the converter sleeps. A read issued while it sleeps first runs a full wake-up frame and drops that frame's data. After the quiet gap the block runs a second full frame on its own, and only that second sample is returned. Between any two frames, chip-select stays high for a programmed quiet interval. Each returned sample carries a protocol error flag. The flag is set when the four bits that come before the data are not all zero.

The state machine has three states. IDLE keeps chip-select high and accepts a command. FRAME holds chip-select low and runs the serial clock. GAP holds chip-select high for the quiet interval. The transitions are as follows:
- IDLE to FRAME on an accepted command.
- FRAME to GAP after the last rising edge of the frame, which is the 16th for a full frame and the 5th for a power-down frame.
- GAP to FRAME when a wake-up frame has just finished and the real read is still pending.
- GAP to IDLE otherwise.

Top module: `adc_host_reader`

## Requirements
- R1: After reset, adc_cs_n=1, adc_sclk=1, result_valid=0 and cmd_ready=1.
- R2: A read frame holds adc_cs_n low for exactly 16 falling and 16 rising edges of adc_sclk. adc_sclk is high whenever adc_cs_n changes.
- R3: Bits are sampled on adc_sclk rising edges, MSB first. result_data is the last 12 of the 16 bits, with bit 11 taken from the 5th bit received. result_valid is a single-cycle pulse in the first cycle that adc_cs_n is high again.
- R4: result_err is 1 with a result if any of the first four received bits is 1, and 0 otherwise.
- R5: A power-down command (cmd_op=1) releases adc_cs_n after exactly 5 falling edges of adc_sclk and produces no result_valid.
- R6: The first read after a power-down runs two full frames and returns only the second frame's data. A read issued from reset, or after another read, runs one frame.
- R7: Between any two frames, adc_cs_n stays high for at least QUIET_CYC system clock cycles.
- R8: adc_sclk has a period of exactly 2*DIV_HALF system clocks inside a frame, and stays high while adc_cs_n is high.
- R9: cmd_ready is 1 only in IDLE. A cmd_valid pulse while cmd_ready=0 is ignored. It starts no frame and does not change the sleep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when cmd_ready=1 |
| cmd_op | input | 1 | 0 = read sample, 1 = enter power-down |
| cmd_ready | output | 1 | Block is idle and will take a command |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_sclk | output | 1 | Converter serial clock, idles high |
| adc_miso | input | 1 | Converter serial data |
| result_valid | output | 1 | One-cycle strobe for a new sample |
| result_data | output | DATA_BITS | 12-bit sample |
| result_err | output | 1 | Leading bits were not zero |

## Verification
A wrong state or frame kind shows up at chip-select within one frame. The frame is cut at the wrong edge count, the strobe is missing or extra, or a wake-up runs one frame instead of two. A miscounted gap or divider appears as a short high time on adc_cs_n, or as a wrong serial clock period within a single clock period. A bad shift register or leading-bit test appears as a wrong value on result_data or result_err, on the strobe of the frame it affects.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_GAP   = 2'd2
    } rd_state_t;

    typedef enum logic [1:0] {
        FK_READ  = 2'd0,
        FK_PWRDN = 2'd1,
        FK_DUMMY = 2'd2
    } frame_kind_t;

    localparam logic OP_READ  = 1'b0;
    localparam logic OP_PWRDN = 1'b1;
endpackage

// File: rtl/adc_rd_count.sv
module adc_rd_count #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (en)  q <= q + 1'b1;
    end
endmodule

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_pulse,
    output logic fall_pulse
);
    logic sclk_q;
    logic wrap;

    generate
        if (DIV_HALF == 1) begin : g_fast
            assign wrap = run;
        end else begin : g_div
            localparam int HW = $clog2(DIV_HALF);
            localparam logic [HW-1:0] HLAST = HW'(DIV_HALF - 1);
            logic [HW-1:0] half_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              half_q <= '0;
                else if (!run)           half_q <= '0;
                else if (half_q == HLAST) half_q <= '0;
                else                     half_q <= half_q + 1'b1;
            end
            assign wrap = run && (half_q == HLAST);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sclk_q <= 1'b1;
        else if (!run)  sclk_q <= 1'b1;
        else if (wrap)  sclk_q <= ~sclk_q;
    end

    assign sclk       = sclk_q;
    assign rise_pulse = wrap && !sclk_q;
    assign fall_pulse = wrap && sclk_q;
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word_next
);
    logic [W-1:0] sh_q;

    assign word_next = {sh_q[W-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sh_q <= '0;
        else if (shift_en) sh_q <= word_next;
    end
endmodule

// File: rtl/adc_host_reader.sv
module adc_host_reader
    import adc_rd_pkg::*;
#(
    parameter int DIV_HALF   = 2,
    parameter int QUIET_CYC  = 6,
    parameter int FRAME_BITS = 16,
    parameter int DATA_BITS  = 12,
    parameter int PD_EDGE    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_op,
    output logic                 cmd_ready,
    output logic                 adc_cs_n,
    output logic                 adc_sclk,
    input  logic                 adc_miso,
    output logic                 result_valid,
    output logic [DATA_BITS-1:0] result_data,
    output logic                 result_err
);
    localparam int LEAD_BITS = FRAME_BITS - DATA_BITS;
    localparam int CW        = $clog2(FRAME_BITS + 1);
    localparam int GW        = $clog2(QUIET_CYC + 1);
    localparam logic [CW-1:0] FULL_LAST = CW'(FRAME_BITS - 1);
    localparam logic [CW-1:0] PD_LAST   = CW'(PD_EDGE - 1);
    localparam logic [GW-1:0] GAP_LAST  = GW'(QUIET_CYC - 1);

    rd_state_t   state_q, state_d;
    frame_kind_t kind_q;
    logic        asleep_q;
    logic        pend_q;

    logic                  run;
    logic                  rise_pulse;
    logic                  fall_pulse;
    logic [CW-1:0]         rise_cnt;
    logic [GW-1:0]         gap_cnt;
    logic [FRAME_BITS-1:0] word_next;
    logic                  accept;
    logic                  frame_end;
    logic                  gap_end;
    logic [CW-1:0]         edge_last;

    adc_rd_sclk #(.DIV_HALF(DIV_HALF)) u_sclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .sclk       (adc_sclk),
        .rise_pulse (rise_pulse),
        .fall_pulse (fall_pulse)
    );

    adc_rd_count #(.W(CW)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_FRAME),
        .en    (rise_pulse),
        .q     (rise_cnt)
    );

    adc_rd_count #(.W(GW)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_GAP),
        .en    (state_q == ST_GAP),
        .q     (gap_cnt)
    );

    adc_rd_shift #(.W(FRAME_BITS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (rise_pulse),
        .din       (adc_miso),
        .word_next (word_next)
    );

    assign edge_last = (kind_q == FK_PWRDN) ? PD_LAST : FULL_LAST;
    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign frame_end = (state_q == ST_FRAME) && rise_pulse && (rise_cnt == edge_last);
    assign gap_end   = (state_q == ST_GAP) && (gap_cnt == GAP_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)    state_d = ST_FRAME;
            ST_FRAME: if (frame_end) state_d = ST_GAP;
            ST_GAP:   if (gap_end)   state_d = pend_q ? ST_FRAME : ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Pin outputs
    always_comb begin
        adc_cs_n  = 1'b1;
        cmd_ready = 1'b0;
        run       = 1'b0;
        unique case (state_q)
            ST_IDLE:  cmd_ready = 1'b1;
            ST_FRAME: begin
                adc_cs_n = 1'b0;
                run      = 1'b1;
            end
            ST_GAP:   ;
            default:  ;
        endcase
    end

    // Frame kind, sleep tracking and pending wake-up read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= FK_READ;
            asleep_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (accept) begin
                if (cmd_op == OP_PWRDN) kind_q <= FK_PWRDN;
                else if (asleep_q)      kind_q <= FK_DUMMY;
                else                    kind_q <= FK_READ;
            end else if (gap_end && pend_q) begin
                kind_q <= FK_READ;
            end
            if (frame_end) asleep_q <= (kind_q == FK_PWRDN);
            if (frame_end && kind_q == FK_DUMMY) pend_q <= 1'b1;
            else if (gap_end)                    pend_q <= 1'b0;
        end
    end

    // Result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_valid <= 1'b0;
            result_data  <= '0;
            result_err   <= 1'b0;
        end else begin
            result_valid <= frame_end && (kind_q == FK_READ);
            if (frame_end && kind_q == FK_READ) begin
                result_data <= word_next[DATA_BITS-1:0];
                result_err  <= |word_next[FRAME_BITS-1 -: LEAD_BITS];
            end
        end
    end

    logic unused_fall;
    assign unused_fall = fall_pulse;
endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker #(
    parameter int QUIET_CYC  = 6,
    parameter int FRAME_BITS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic cmd_ready,
    input logic result_valid
);
    localparam int QW = $clog2(QUIET_CYC + 2);
    localparam int FW = $clog2(FRAME_BITS + 2);

    logic [QW-1:0] high_cnt;
    logic [FW-1:0] fall_cnt;
    logic          sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_cnt <= QW'(QUIET_CYC);
            fall_cnt <= '0;
            sclk_d   <= 1'b1;
        end else begin
            sclk_d <= sclk;
            if (!cs_n)                      high_cnt <= '0;
            else if (high_cnt < QW'(QUIET_CYC)) high_cnt <= high_cnt + 1'b1;
            if (cs_n)                       fall_cnt <= '0;
            else if (sclk_d && !sclk)       fall_cnt <= fall_cnt + 1'b1;
        end
    end

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk); // R8
    AST_CS_EDGE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n != $past(cs_n)) |-> sclk); // R2
    AST_FALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fall_cnt <= FW'(FRAME_BITS)); // R2
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R3
    AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $rose(cs_n)); // R3
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> cs_n); // R9
    AST_QUIET_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (high_cnt >= QW'(QUIET_CYC))); // R7
endmodule

bind adc_host_reader adc_rd_checker #(
    .QUIET_CYC  (QUIET_CYC),
    .FRAME_BITS (FRAME_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (adc_cs_n),
    .sclk         (adc_sclk),
    .cmd_ready    (cmd_ready),
    .result_valid (result_valid)
);

// File: tb/tb_adc_host_reader.sv
`timescale 1ns/1ps
module tb_adc_host_reader;
    localparam int DIV_HALF  = 2;
    localparam int QUIET_CYC = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_op = 1'b0;
    logic        cmd_ready;
    logic        adc_cs_n;
    logic        adc_sclk;
    logic        adc_miso = 1'b0;
    logic        result_valid;
    logic [11:0] result_data;
    logic        result_err;

    adc_host_reader #(.DIV_HALF(DIV_HALF), .QUIET_CYC(QUIET_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ready(cmd_ready), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
        .adc_miso(adc_miso), .result_valid(result_valid),
        .result_data(result_data), .result_err(result_err)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // converter model and port monitor, all sampled on the falling clk edge
    logic [15:0] words [0:255];
    int   wr_ptr = 0, rd_ptr = 0;
    logic [15:0] cur_word = '0;
    int   bcnt = 0, fall_cnt = 0, last_falls = 0, frames_done = 0;
    int   hi_run = 0, min_gap = 1000000, ncyc = 0, last_fall_cyc = 0;
    int   rcv_cnt = 0, valid_bad = 0;
    bit   period_bad = 0, sclk_low_idle = 0, seen_frame = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b1;
    logic [11:0] got_data = '0;
    logic        got_err = 1'b0;

    always @(negedge clk) begin
        ncyc++;
        if (rst_n) begin
            if (adc_cs_n && !adc_sclk) sclk_low_idle = 1;
            if (prev_cs && !adc_cs_n) begin
                if (seen_frame && hi_run < min_gap) min_gap = hi_run;
                seen_frame = 1;
                cur_word = words[rd_ptr % 256];
                rd_ptr++;
                bcnt = 0; fall_cnt = 0; adc_miso = 1'b0;
            end
            if (!adc_cs_n && prev_sclk && !adc_sclk) begin
                if (fall_cnt > 0 && (ncyc - last_fall_cyc) != 2 * DIV_HALF) period_bad = 1;
                last_fall_cyc = ncyc;
                fall_cnt++;
                bcnt++;
                if (bcnt <= 16) adc_miso = cur_word[16 - bcnt];
            end
            if (!prev_cs && adc_cs_n) begin
                last_falls = fall_cnt;
                frames_done++;
            end
            if (result_valid) begin
                rcv_cnt++;
                got_data = result_data;
                got_err  = result_err;
                if (prev_cs || !adc_cs_n) valid_bad++;
            end
            if (adc_cs_n) hi_run++; else hi_run = 0;
            prev_cs   = adc_cs_n;
            prev_sclk = adc_sclk;
        end
    end

    function automatic logic [11:0] exp_data(logic [15:0] w);
        return w[11:0];
    endfunction
    function automatic logic exp_err(logic [15:0] w);
        return w[15:12] != 4'h0;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(logic op);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
    endtask

    bit model_asleep = 0;

    // one command with expected outcome computed from the requirements
    task automatic run_cmd(logic op, logic [15:0] w, logic [15:0] dummy);
        int r0, f0;
        r0 = rcv_cnt; f0 = frames_done;
        if (op) begin
            words[wr_ptr % 256] = w; wr_ptr++;
            issue(1'b1);
            check(last_falls == 5, "R5 falls", last_falls, 5);
            check(rcv_cnt == r0, "R5 no result", rcv_cnt - r0, 0);
            model_asleep = 1;
        end else begin
            if (model_asleep) begin
                words[wr_ptr % 256] = dummy; wr_ptr++;
            end
            words[wr_ptr % 256] = w; wr_ptr++;
            issue(1'b0);
            check(frames_done - f0 == (model_asleep ? 2 : 1), "R6 frames", frames_done - f0, model_asleep ? 2 : 1);
            check(last_falls == 16, "R2 falls", last_falls, 16);
            check(rcv_cnt == r0 + 1, "R3 one result", rcv_cnt - r0, 1);
            check(got_data == exp_data(w), "R3 data", got_data, exp_data(w));
            check(got_err == exp_err(w), "R4 err", got_err, exp_err(w));
            model_asleep = 0;
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", n_checks, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(adc_cs_n == 1'b1, "R1 cs_n", adc_cs_n, 1);
        check(adc_sclk == 1'b1, "R1 sclk", adc_sclk, 1);
        check(result_valid == 1'b0, "R1 valid", result_valid, 0);
        check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed reads: R3, R4, R6 (first read from reset is a single frame)
        run_cmd(1'b0, 16'h0ABC, 16'h0);
        run_cmd(1'b0, 16'h0FFF, 16'h0);
        run_cmd(1'b0, 16'h0000, 16'h0);
        run_cmd(1'b0, 16'h8123, 16'h0);
        run_cmd(1'b0, 16'h1800, 16'h0);

        // power-down then wake-up read: R5, R6
        run_cmd(1'b1, 16'hFFFF, 16'h0);
        run_cmd(1'b0, 16'h0555, 16'h0AAA);
        // power-down twice then wake
        run_cmd(1'b1, 16'h0000, 16'h0);
        run_cmd(1'b1, 16'h0000, 16'h0);
        run_cmd(1'b0, 16'h0001, 16'hF777);

        // R9: command pulse while busy is ignored
        begin
            int f0;
            words[wr_ptr % 256] = 16'h0321; wr_ptr++;
            f0 = frames_done;
            while (!cmd_ready) @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 1'b0;
            @(negedge clk);
            cmd_op = 1'b1;
            check(cmd_ready == 1'b0, "R9 ready low busy", cmd_ready, 0);
            @(negedge clk);
            cmd_valid = 1'b0;
            while (!cmd_ready) @(negedge clk);
            repeat (60) @(negedge clk);
            check(frames_done == f0 + 1, "R9 no extra frame", frames_done - f0, 1);
            check(adc_cs_n == 1'b1, "R9 cs idle", adc_cs_n, 1);
            check(got_data == 12'h321, "R9 data", got_data, 12'h321);
            // sleep state untouched: next read is a single frame
            run_cmd(1'b0, 16'h0456, 16'h0);
        end

        // constrained random mix
        for (int i = 0; i < 40; i++) begin
            logic [15:0] w, d;
            logic op;
            op = ($urandom % 5) == 0;
            w  = {(($urandom % 4) == 0) ? 4'($urandom % 15 + 1) : 4'h0, 12'($urandom)};
            d  = 16'($urandom);
            run_cmd(op, w, d);
        end
        run_cmd(1'b0, 16'h0FED, 16'h0123);

        // R7 quiet gap, R8 clock period and idle level, R3 strobe alignment
        check(min_gap >= QUIET_CYC, "R7 gap", min_gap, QUIET_CYC);
        check(!period_bad, "R8 period", period_bad, 0);
        check(!sclk_low_idle, "R8 sclk idle high", sclk_low_idle, 0);
        check(valid_bad == 0, "R3 strobe at cs release", valid_bad, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule